// File: doc/BRIEF.md
# Timer Compare Interrupt Unit

This unit sits beside a simple processor core and combines a timer with the logic that decides whether an interrupt is pending. A free-running counter advances by one on every tick-enable pulse. A compare register holds a value that only software changes. When the counter steps onto the compare value, a timer pending flag is latched. That flag stays set until software writes the compare register again, which is how a timer handler acknowledges the interrupt and arms the next one.

Eight pending sources sit side by side: the timer flag, five external hardware lines and two software-settable bits. Each one is gated by its own bit of an 8-bit mask. The gated result is then qualified by a global enable and by two level flags that block interrupts while the core is handling an exception or an error. The result is a single request line to the core. All state is reached through one small register port with a two-bit address and a combinational read path.

Top module: `tmr_irq_unit`

## Requirements
- R1: After synchronous reset, count, compare, status and cause all read zero and `irq_req` is low.
- R2: Address 0 is the count register. It increments by one, modulo 2^CNT_W, on every cycle with `tick_en` high. It wraps from all ones to zero. A write loads `reg_wdata` and takes priority over a tick in the same cycle.
- R3: Address 1 is the compare register. It reads back the last value written, zero-extended to 32 bits when CNT_W is below 32, and it never changes without a write.
- R4: A tick that moves the count onto the compare value sets the timer pending bit, which reads as cause bit 15. Loading the count with the compare value through a write does not set it.
- R5: The timer pending bit stays set as the count moves on, and is cleared by any write to compare. If a compare write and a match happen in the same cycle, the bit ends cleared.
- R6: Address 3 is the cause register, with pending bits in 15..8. Software writes the two software pending bits through bits 9..8. Write data in bits 15..10 has no effect, and all other bits read zero.
- R7: External line `hw_irq_in[k]` appears as cause bit 10+k after SYNC_STAGES clock edges.
- R8: Address 2 is the status register: bit 0 global enable, bit 1 exception level, bit 2 error level, bits 15..8 the mask. Other bits read zero.
- R9: `irq_req` is high exactly when some pending bit i has mask bit i set, the enable bit is 1, and both level bits are 0. Mask bit 7 gates the timer, bits 6..2 gate the external lines, and bits 1..0 gate the software bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count advance pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 count, 1 compare, 2 status, 3 cause) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| hw_irq_in | input | 5 | Asynchronous external interrupt lines |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench builds the unit with CNT_W = 8 and SYNC_STAGES = 2. With an 8-bit counter, every compare value from 0 to 255 can be armed and matched, including the matches that need the count to wrap through zero. The gating logic is swept over all 128 combinations of software and external pending bits, with and without the timer bit. Each combination is tried against four mask patterns and all eight combinations of the enable and level flags.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SRC   = 8;
    localparam int NUM_SW    = 2;
    localparam int NUM_HW    = 5;
    localparam int TIMER_IDX = 7;
    localparam int FIELD_LO  = 8;

    typedef enum logic [1:0] {
        RA_COUNT   = 2'd0,
        RA_COMPARE = 2'd1,
        RA_STATUS  = 2'd2,
        RA_CAUSE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               erl;
        logic               exl;
        logic               ie;
    } status_t;

    function automatic logic [DATA_W-1:0] status_word(status_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = s.ie;
        w[1] = s.exl;
        w[2] = s.erl;
        w[FIELD_LO +: NUM_SRC] = s.mask;
        return w;
    endfunction

    function automatic status_t status_from_word(logic [DATA_W-1:0] w);
        status_t s;
        s.ie   = w[0];
        s.exl  = w[1];
        s.erl  = w[2];
        s.mask = w[FIELD_LO +: NUM_SRC];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] cause_word(logic [NUM_SRC-1:0] ip);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FIELD_LO +: NUM_SRC] = ip;
        return w;
    endfunction

endpackage

// File: rtl/tmr_cnt_cmp.sv
module tmr_cnt_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             timer_pend
);

    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign hit     = tick_en && !cnt_we && (cnt_inc == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cmp_q      <= '0;
            timer_pend <= 1'b0;
        end else begin
            if (cnt_we) begin
                cnt_q <= wdata;
            end else if (tick_en) begin
                cnt_q <= cnt_inc;
            end
            if (cmp_we) begin
                cmp_q      <= wdata;
                timer_pend <= 1'b0;
            end else if (hit) begin
                timer_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else if (STAGES == 1) begin
                chain <= d[b];
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_we,
    input  logic                  cause_we,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_HW-1:0]     hw_pend,
    input  logic                  timer_pend,
    output status_t               st_q,
    output logic [NUM_SRC-1:0]    ip,
    output logic                  irq_req
);

    logic [NUM_SW-1:0] sw_q;
    logic              any_src;
    logic              gate_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            sw_q <= '0;
        end else begin
            if (st_we) begin
                st_q <= status_from_word(wdata);
            end
            if (cause_we) begin
                sw_q <= wdata[FIELD_LO +: NUM_SW];
            end
        end
    end

    assign ip        = {timer_pend, hw_pend, sw_q};
    assign any_src   = |(ip & st_q.mask);
    assign gate_open = st_q.ie && !st_q.exl && !st_q.erl;
    assign irq_req   = any_src && gate_open;

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_irq_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_HW-1:0]     hw_irq_in,
    output logic                  irq_req
);

    reg_addr_e          sel;
    logic               cnt_we, cmp_we, st_we, cause_we;
    logic [CNT_W-1:0]   cnt_q, cmp_q;
    logic               timer_pend;
    logic [NUM_HW-1:0]  hw_pend;
    status_t            st_q;
    logic [NUM_SRC-1:0] ip;

    assign sel      = reg_addr_e'(reg_addr);
    assign cnt_we   = reg_we && (sel == RA_COUNT);
    assign cmp_we   = reg_we && (sel == RA_COMPARE);
    assign st_we    = reg_we && (sel == RA_STATUS);
    assign cause_we = reg_we && (sel == RA_CAUSE);

    tmr_cnt_cmp #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .cnt_we     (cnt_we),
        .cmp_we     (cmp_we),
        .wdata      (reg_wdata[CNT_W-1:0]),
        .cnt_q      (cnt_q),
        .cmp_q      (cmp_q),
        .timer_pend (timer_pend)
    );

    tmr_sync #(.W(NUM_HW), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (hw_irq_in),
        .q   (hw_pend)
    );

    tmr_irq_ctrl ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .st_we      (st_we),
        .cause_we   (cause_we),
        .wdata      (reg_wdata),
        .hw_pend    (hw_pend),
        .timer_pend (timer_pend),
        .st_q       (st_q),
        .ip         (ip),
        .irq_req    (irq_req)
    );

    always_comb begin
        unique case (sel)
            RA_COUNT:   reg_rdata = DATA_W'(cnt_q);
            RA_COMPARE: reg_rdata = DATA_W'(cmp_q);
            RA_STATUS:  reg_rdata = status_word(st_q);
            default:    reg_rdata = cause_word(ip);
        endcase
    end

endmodule

// File: rtl/tmr_irq_unit_chk.sv
module tmr_irq_unit_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic             timer_pend,
    input logic             st_ie,
    input logic             st_exl,
    input logic             st_erl,
    input logic             irq_req
);

    logic wr_cnt, wr_cmp;
    assign wr_cnt = reg_we && (reg_addr == 2'd0);
    assign wr_cmp = reg_we && (reg_addr == 2'd1);

    // R2: tick advances the count by one modulo 2^CNT_W
    a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_cnt) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

    // R2: write wins over tick
    a_r2_write_load: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt_q == $past(reg_wdata[CNT_W-1:0])));

    // R3: compare holds without a write
    a_r3_cmp_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_cmp |=> $stable(cmp_q));

    // R4: stepping onto compare sets the timer pending bit
    a_r4_match_sets: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_cnt && !wr_cmp && (CNT_W'(cnt_q + CNT_W'(1)) == cmp_q)) |=> timer_pend);

    // R5: compare write clears, otherwise pending holds
    a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_cmp |=> !timer_pend);

    a_r5_pend_holds: assert property (@(posedge clk) disable iff (rst)
        (timer_pend && !wr_cmp) |=> timer_pend);

    // R9: request only with enable set and both level flags clear
    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (st_ie && !st_exl && !st_erl));

endmodule

bind tmr_irq_unit tmr_irq_unit_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .cnt_q      (cnt_q),
    .cmp_q      (cmp_q),
    .timer_pend (timer_pend),
    .st_ie      (st_q.ie),
    .st_exl     (st_q.exl),
    .st_erl     (st_q.erl),
    .irq_req    (irq_req)
);

// File: tb/tmr_irq_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_unit_tb_top;

    localparam int TB_CNT_W = 8;
    localparam int TB_SYNC  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  hw_irq_in = '0;
    logic        irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tmr_irq_unit #(.CNT_W(TB_CNT_W), .SYNC_STAGES(TB_SYNC)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hw_irq_in (hw_irq_in),
        .irq_req   (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  exp_cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 count", v, 0);
        rd(2'd1, v); check("R1 compare", v, 0);
        rd(2'd2, v); check("R1 status", v, 0);
        rd(2'd3, v); check("R1 cause", v, 0);
        check("R1 irq", {31'b0, irq_req}, 0);

        // R3 compare readback, truncated to CNT_W and stable under ticks
        wr(2'd1, 32'h1234_56A5);
        rd(2'd1, v); check("R3 readback", v, 32'hA5);
        tick(); tick();
        rd(2'd1, v); check("R3 stable", v, 32'hA5);

        // R2 wrap and write priority
        wr(2'd0, 32'hFF);
        tick();
        rd(2'd0, v); check("R2 wrap", v, 0);
        @(negedge clk);
        tick_en = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h33;
        @(negedge clk);
        tick_en = 1'b0; reg_we = 1'b0;
        rd(2'd0, v); check("R2 write over tick", v, 32'h33);

        // R4 load equal to compare does not set pending
        wr(2'd1, 32'h40);
        wr(2'd0, 32'h40);
        rd(2'd3, v); check("R4 load no match", v, 0);
        tick();
        rd(2'd3, v); check("R4 past no match", v, 0);

        // R4/R5 exhaustive compare sweep with wrap-through
        for (int c = 0; c < 256; c++) begin
            wr(2'd1, 32'(c));
            wr(2'd0, 32'((c - 3) & 8'hFF));
            tick(); tick();
            rd(2'd3, v); check("R4 before match", v, 0);
            tick();
            rd(2'd3, v); check("R4 on match", v, 32'h8000);
            rd(2'd0, v); check("R2 count at match", v, 32'(c));
            tick();
            exp_cnt = 8'(c + 1);
            rd(2'd0, v); check("R2 count past", v, {24'b0, exp_cnt});
            rd(2'd3, v); check("R5 holds", v, 32'h8000);
            wr(2'd1, 32'(c));
            rd(2'd3, v); check("R5 write clears", v, 0);
        end

        // R5 same-cycle compare write and match
        wr(2'd1, 32'h10);
        wr(2'd0, 32'h0F);
        @(negedge clk);
        tick_en = 1'b1; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h10;
        @(negedge clk);
        tick_en = 1'b0; reg_we = 1'b0;
        rd(2'd3, v); check("R5 write wins", v, 0);
        rd(2'd0, v); check("R5 count moved", v, 32'h10);

        // R6 only software bits writable
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check("R6 sw only", v, 32'h0300);
        wr(2'd3, 32'h0);
        rd(2'd3, v); check("R6 sw clear", v, 0);

        // R7/R8/R9 gating sweep
        for (int t = 0; t < 2; t++) begin
            wr(2'd1, 32'h05);
            if (t == 1) begin
                wr(2'd0, 32'h04);
                tick();
            end
            for (int p = 0; p < 128; p++) begin
                logic [7:0] ipx;
                logic [7:0] masks [4];
                ipx = {t[0], p[6:0]};
                wr(2'd3, {22'b0, p[1:0], 8'h00});
                @(negedge clk);
                hw_irq_in = p[6:2];
                repeat (TB_SYNC) @(negedge clk);
                rd(2'd3, v); check("R7 cause sources", v, {16'b0, ipx, 8'b0});
                masks[0] = ipx; masks[1] = ~ipx; masks[2] = 8'hFF;
                masks[3] = 8'(1 << (p % 8));
                for (int m = 0; m < 4; m++) begin
                    for (int s = 0; s < 8; s++) begin
                        logic exp_irq;
                        wr(2'd2, 32'hFFFF_0000 | {16'b0, masks[m], 5'b11111, s[2:0]} & 32'hFFFF_FF07 | 32'hFFFF_0000);
                        rd(2'd2, v); check("R8 status readback", v, {16'b0, masks[m], 5'b0, s[2:0]});
                        exp_irq = (|(ipx & masks[m])) && (s[2:0] == 3'b001);
                        check("R9 irq", {31'b0, irq_req}, {31'b0, exp_irq});
                    end
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule